// File: doc/BRIEF.md
# Synchronous Trace Port Serializer

This block drains a stream of already formatted trace bytes, offered on a valid/ready handshake, and shifts them out over a synchronous trace port. The port has one, two or four data pins and an output trace clock that toggles on every rising edge of the block clock. The trace clock therefore runs at half the block clock rate, and a receiver samples the data on both of its edges.

A small one-hot size register selects the pin count at run time. A new size is picked up only when the next byte starts, so no byte is ever split across two widths. When software raises the enable input, the port starts running after a fixed two-cycle delay.

The port never idles while it is running. If no formatted byte is waiting when a byte slot opens, the block sends the frame synchronization word 0x7FFFFFFF instead. It always sends that word whole, so a receiver can realign to frames at any point.

Top module: `trace_port_serializer`

## Requirements
- R1: After reset, sizeOut reads 4'b0001 (one pin), and traceClk, traceData and inReady are all 0.
- R2: A sizeWr with sizeWrData equal to 4'b0001 (1 pin), 4'b0010 (2 pins) or 4'b1000 (4 pins) updates the size register, which reads back on sizeOut from the next cycle. Any other value, including 4'b0100, zero or several bits set, is ignored and the previous size is kept.
- R3: If enable is first sampled high at clock edge k, traceClk and traceData stay 0 after edges k and k+1, and traceClk goes high at edge k+2, when the first byte is loaded.
- R4: While the port runs, traceClk inverts at every clock edge. Two edges after enable is sampled low, traceClk, traceData and inReady are 0.
- R5: Each byte is sent least significant bit first in 8, 4 or 2 beats (1, 2 or 4 pins), one beat per clock. Within a beat, traceData[0] carries the least significant of the bits sent.
- R6: Data pins not used by the current width are driven 0.
- R7: A byte is sent at the width held in the size register at the clock edge that loads it. A size write made in the middle of a byte does not change that byte.
- R8: If no byte is accepted when a byte slot opens, the block sends the sync word 0x7FFFFFFF as the bytes FF, FF, FF, 7F. Once the first of these bytes has started, the remaining three follow with inReady held low.
- R9: A byte is taken at an edge where inValid and inReady are both high. inReady is high only when the port is running and a byte slot opens. Accepted bytes appear on the port in the order they were taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Trace input clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Trace port enable |
| sizeWr | input | 1 | Size register write strobe |
| sizeWrData | input | 4 | One-hot size value to write |
| inValid | input | 1 | Formatted byte available |
| inData | input | 8 | Formatted trace byte |
| inReady | output | 1 | Byte taken this cycle when inValid is high |
| sizeOut | output | 4 | Current size register value |
| traceClk | output | 1 | Output trace clock, half the clk rate |
| traceData | output | 4 | Trace data pins |

## Verification
A beat counter that is off by one, or a width latched at the wrong moment, leaves every later byte misaligned. Rebuilding the byte from the pins then produces wrong values within one byte time, at most eight clocks. A wrong sync position shows up as a 7F in place of an FF, or as a data byte arriving inside a sync word, no later than the fourth filler byte. A fault in the enable delay or in the clock gating shows on traceClk in the first cycles after enable changes. A size register that takes an illegal value shows at once on sizeOut.

// File: rtl/trace_ser_pkg.sv
package trace_ser_pkg;
  localparam int BYTE_W     = 8;
  localparam int PINS_MAX   = 4;
  localparam int SIZE_W     = 4;
  localparam int FILL_BYTES = 4;
  localparam int FILL_IDX_W = $clog2(FILL_BYTES);
  localparam int SYNC_W     = FILL_BYTES * BYTE_W;
  localparam int BEAT_W     = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    W_ONE  = 2'd0,
    W_TWO  = 2'd1,
    W_FOUR = 2'd2
  } widthE;

  typedef struct packed {
    logic                  run;
    logic                  load;
    logic                  fill;
    logic [FILL_IDX_W-1:0] fillIdx;
    widthE                 width;
  } strobeT;
endpackage

// File: rtl/trace_ser_ctrl.sv
module trace_ser_ctrl
  import trace_ser_pkg::*;
#(
  parameter int EN_DELAY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sizeWr,
  input  logic [SIZE_W-1:0] sizeWrData,
  input  logic              inValid,
  output logic              inReady,
  output logic [SIZE_W-1:0] sizeOut,
  output strobeT            stb
);
  localparam logic [BEAT_W-1:0] LAST_ONE  = BEAT_W'(BYTE_W - 1);
  localparam logic [BEAT_W-1:0] LAST_TWO  = BEAT_W'(BYTE_W / 2 - 1);
  localparam logic [BEAT_W-1:0] LAST_FOUR = BEAT_W'(BYTE_W / 4 - 1);
  localparam logic [FILL_IDX_W-1:0] FILL_LAST = FILL_IDX_W'(FILL_BYTES - 1);

  logic [EN_DELAY-1:0]   enPipe;
  logic                  active;
  logic                  loaded;
  logic [BEAT_W-1:0]     beatCnt;
  logic [BEAT_W-1:0]     lastBeat;
  logic [FILL_IDX_W-1:0] fillIdx;
  logic [SIZE_W-1:0]     sizeReg;
  widthE                 curWidth;
  widthE                 nextWidth;
  logic                  boundary;
  logic                  takeData;
  logic                  fillNow;
  logic                  sizeLegal;

  generate
    if (EN_DELAY == 1) begin : g_delay1
      always_ff @(posedge clk) begin
        if (!rstN) enPipe <= '0;
        else       enPipe <= enable;
      end
    end else begin : g_delayN
      always_ff @(posedge clk) begin
        if (!rstN) enPipe <= '0;
        else       enPipe <= {enPipe[EN_DELAY-2:0], enable};
      end
    end
  endgenerate

  assign active = enPipe[EN_DELAY-1];

  always_comb begin
    sizeLegal = (sizeWrData == SIZE_W'(4'b0001)) ||
                (sizeWrData == SIZE_W'(4'b0010)) ||
                (sizeWrData == SIZE_W'(4'b1000));
    case (sizeReg)
      SIZE_W'(4'b0010): nextWidth = W_TWO;
      SIZE_W'(4'b1000): nextWidth = W_FOUR;
      default:          nextWidth = W_ONE;
    endcase
    case (curWidth)
      W_ONE:   lastBeat = LAST_ONE;
      W_TWO:   lastBeat = LAST_TWO;
      default: lastBeat = LAST_FOUR;
    endcase
  end

  assign boundary = active && (!loaded || (beatCnt == lastBeat));
  assign inReady  = boundary && (fillIdx == '0);
  assign takeData = inReady && inValid;
  assign fillNow  = boundary && !takeData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sizeReg <= SIZE_W'(4'b0001);
    end else if (sizeWr && sizeLegal) begin
      sizeReg <= sizeWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loaded   <= 1'b0;
      beatCnt  <= '0;
      fillIdx  <= '0;
      curWidth <= W_ONE;
    end else if (!active) begin
      loaded  <= 1'b0;
      beatCnt <= '0;
      fillIdx <= '0;
    end else if (boundary) begin
      loaded   <= 1'b1;
      beatCnt  <= '0;
      curWidth <= nextWidth;
      if (fillNow) fillIdx <= (fillIdx == FILL_LAST) ? '0 : fillIdx + 1'b1;
    end else begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  assign sizeOut     = sizeReg;
  assign stb.run     = active;
  assign stb.load    = boundary;
  assign stb.fill    = fillNow;
  assign stb.fillIdx = fillIdx;
  assign stb.width   = nextWidth;

  AST_SIZE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (sizeWr && !sizeLegal) |=> $stable(sizeReg)); // R2
  AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(sizeReg) == 1) && !sizeReg[2]); // R2
  AST_NO_READY_MIDWORD: assert property (@(posedge clk) disable iff (!rstN)
    (fillIdx != '0) |-> !inReady); // R8
  AST_READY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> $past(enPipe[0])); // R9
endmodule

// File: rtl/trace_ser_dp.sv
module trace_ser_dp
  import trace_ser_pkg::*;
#(
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h7FFF_FFFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              stb,
  input  logic [BYTE_W-1:0]   inData,
  output logic                traceClk,
  output logic [PINS_MAX-1:0] traceData
);
  logic [BYTE_W-1:0] shReg;
  logic [BYTE_W-1:0] fillByte;
  logic [BYTE_W-1:0] shNext;
  widthE             widthQ;
  logic              clkQ;

  assign fillByte = SYNC_WORD[stb.fillIdx*BYTE_W +: BYTE_W];

  always_comb begin
    case (widthQ)
      W_ONE:   shNext = shReg >> 1;
      W_TWO:   shNext = shReg >> 2;
      default: shNext = shReg >> 4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      widthQ <= W_ONE;
      clkQ   <= 1'b0;
    end else if (!stb.run) begin
      shReg <= '0;
      clkQ  <= 1'b0;
    end else begin
      clkQ <= ~clkQ;
      if (stb.load) begin
        shReg  <= stb.fill ? fillByte : inData;
        widthQ <= stb.width;
      end else begin
        shReg <= shNext;
      end
    end
  end

  assign traceClk = clkQ;

  always_comb begin
    traceData = '0;
    case (widthQ)
      W_ONE:   traceData[0]   = shReg[0];
      W_TWO:   traceData[1:0] = shReg[1:0];
      default: traceData[3:0] = shReg[3:0];
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.run |=> (!traceClk && (traceData == '0))); // R4
  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.run) |-> (traceClk != $past(traceClk))); // R4
  AST_WIDTH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ != $past(widthQ)) |-> $past(stb.load)); // R7
  AST_PINS_UNUSED: assert property (@(posedge clk) disable iff (!rstN)
    (widthQ == W_ONE) |-> (traceData[3:1] == '0)); // R6
endmodule

// File: rtl/trace_port_serializer.sv
module trace_port_serializer
  import trace_ser_pkg::*;
#(
  parameter int                EN_DELAY  = 2,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 32'h7FFF_FFFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                sizeWr,
  input  logic [SIZE_W-1:0]   sizeWrData,
  input  logic                inValid,
  input  logic [BYTE_W-1:0]   inData,
  output logic                inReady,
  output logic [SIZE_W-1:0]   sizeOut,
  output logic                traceClk,
  output logic [PINS_MAX-1:0] traceData
);
  strobeT stb;

  trace_ser_ctrl #(.EN_DELAY(EN_DELAY)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .sizeWr     (sizeWr),
    .sizeWrData (sizeWrData),
    .inValid    (inValid),
    .inReady    (inReady),
    .sizeOut    (sizeOut),
    .stb        (stb)
  );

  trace_ser_dp #(.SYNC_WORD(SYNC_WORD)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inData    (inData),
    .traceClk  (traceClk),
    .traceData (traceData)
  );
endmodule

// File: tb/sim_trace_port_serializer.sv
`timescale 1ns/1ps
module sim_trace_port_serializer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       sizeWr = 1'b0;
  logic [3:0] sizeWrData = 4'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h0;
  logic       inReady;
  logic [3:0] sizeOut;
  logic       traceClk;
  logic [3:0] traceData;

  int nChecks = 0;
  int nFails  = 0;
  int seed    = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];

  bit         monEn = 1'b0;
  bit         monRun = 1'b0;
  int         monW = 1;
  int         monBeat = 0;
  logic [7:0] monByte = 8'h0;
  bit         monSpare = 1'b0;
  int         fillPos = 0;
  logic       prevTclk = 1'b0;
  logic [3:0] prevSize = 4'b0001;

  always #2 clk = ~clk;

  trace_port_serializer u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .sizeWr(sizeWr),
    .sizeWrData(sizeWrData), .inValid(inValid), .inData(inData),
    .inReady(inReady), .sizeOut(sizeOut), .traceClk(traceClk),
    .traceData(traceData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int widthOf(input logic [3:0] s);
    case (s)
      4'b0010: return 2;
      4'b1000: return 4;
      default: return 1;
    endcase
  endfunction

  // Monitor: rebuilds bytes from the pins and checks them against the scoreboard
  always @(negedge clk) begin
    if (monEn) begin
      if (monRun) chk(traceClk != prevTclk, "R4 trace clock toggle", traceClk, ~prevTclk);
      if (!monRun && traceClk) begin
        monRun = 1'b1;
        monW = widthOf(prevSize);
        monBeat = 0;
        monByte = 8'h0;
        monSpare = 1'b0;
      end
      if (monRun) begin
        for (int k = 0; k < 4; k++) begin
          if (k < monW) monByte[monBeat*monW + k] = traceData[k];
          else if (traceData[k]) monSpare = 1'b1;
        end
        monBeat++;
        if (monBeat * monW == 8) begin
          chk(!monSpare, "R6 unused pins low", monSpare, 0);
          if (monByte == 8'hFF || monByte == 8'h7F) begin
            chk(monByte == ((fillPos == 3) ? 8'h7F : 8'hFF), "R8 sync byte order",
                monByte, (fillPos == 3) ? 8'h7F : 8'hFF);
            fillPos = (fillPos + 1) % 4;
          end else begin
            chk(fillPos == 0, "R8 data inside sync word", fillPos, 0);
            if (expQ.size() == 0) begin
              chk(1'b0, "R9 unexpected byte", monByte, 0);
            end else begin
              logic [7:0] e;
              e = expQ.pop_front();
              chk(monByte == e, "R5 R7 R9 byte value", monByte, e);
            end
          end
          monW = widthOf(sizeOut);
          monBeat = 0;
          monByte = 8'h0;
          monSpare = 1'b0;
        end
      end
    end
    prevTclk = traceClk;
    prevSize = sizeOut;
  end

  // Driver: offers bytes and pushes each accepted one onto the scoreboard
  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((seed * 29 + 3) % 127);
      seed++;
      inValid = 1'b1;
      inData = b;
      while (!inReady) @(negedge clk);
      expQ.push_back(b);
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic writeSize(input logic [3:0] v);
    sizeWr = 1'b1;
    sizeWrData = v;
    @(negedge clk);
    sizeWr = 1'b0;
  endtask

  task automatic drain();
    repeat (60) @(negedge clk);
    chk(expQ.size() == 0, "R9 all bytes sent", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sizeOut == 4'b0001, "R1 size reset", sizeOut, 4'b0001);
    chk(traceClk == 1'b0, "R1 trace clock reset", traceClk, 0);
    chk(traceData == 4'h0, "R1 data reset", traceData, 0);
    chk(inReady == 1'b0, "R1 ready reset", inReady, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: enable delay, then idle sync fill (R8)
    monRun = 1'b0; fillPos = 0; monEn = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    chk(traceClk == 1'b0, "R3 clock held edge k", traceClk, 0);
    chk(inReady == 1'b0, "R9 ready while starting", inReady, 0);
    @(negedge clk);
    chk(traceClk == 1'b0, "R3 clock held edge k+1", traceClk, 0);
    chk(traceData == 4'h0, "R3 data held edge k+1", traceData, 0);
    @(negedge clk);
    chk(traceClk == 1'b1, "R3 clock starts edge k+2", traceClk, 1);
    repeat (70) @(negedge clk);

    // one pin data
    sendBytes(6);
    drain();

    // R2: legal size, then illegal writes ignored
    writeSize(4'b0010);
    chk(sizeOut == 4'b0010, "R2 legal size 2 pins", sizeOut, 4'b0010);
    sendBytes(8);
    writeSize(4'b0100);
    chk(sizeOut == 4'b0010, "R2 size bit2 ignored", sizeOut, 4'b0010);
    writeSize(4'b0011);
    chk(sizeOut == 4'b0010, "R2 two bits ignored", sizeOut, 4'b0010);
    writeSize(4'b0000);
    chk(sizeOut == 4'b0010, "R2 zero ignored", sizeOut, 4'b0010);
    writeSize(4'b1001);
    chk(sizeOut == 4'b0010, "R2 mixed ignored", sizeOut, 4'b0010);
    sendBytes(4);

    // R7: width changes written mid-byte
    writeSize(4'b1000);
    chk(sizeOut == 4'b1000, "R2 legal size 4 pins", sizeOut, 4'b1000);
    sendBytes(10);
    writeSize(4'b0001);
    sendBytes(3);
    writeSize(4'b1000);
    repeat (20) @(negedge clk);
    sendBytes(5);
    drain();

    // R4: disable quiets the port
    monEn = 1'b0;
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(traceClk == 1'b0, "R4 clock low when off", traceClk, 0);
    chk(traceData == 4'h0, "R4 data low when off", traceData, 0);
    chk(inReady == 1'b0, "R4 ready low when off", inReady, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule